// File: doc/BRIEF.md
# Key-Guarded Power Control Register Block

This block sits on an 8-bit microcontroller register bus. It holds a power control register whose contents can only change when the bus write just before it placed an unlock key in a key register. The power register carries a metering shutdown flag and a core shutdown request. It also carries a 3-bit divide code, and from that code the block makes a core clock enable that pulses once every 2^code base cycles.

Next to it are four byte-wide scratch registers. A system reset leaves them alone, and only a power-loss reset clears them. Firmware uses them to keep small values across warm restarts.

The bus is a simple one: address, write data, write strobe, read strobe and combinational read data. The read data is valid in the same cycle as the read strobe and is zero when no readable register is addressed.

Top module: `pwr_key_ctl`

## Requirements
- R1: After either reset, the power register (address 0xC5) reads 0x02, both shutdown outputs are 0, and the key register (address 0xC1) reads 0 at all times.
- R2: A write of 0xA7 to 0xC1 unlocks the power register for the next bus write only. If that next write targets 0xC5, it is accepted. Reads between the two writes do not cancel the unlock.
- R3: A write to 0xC5 without an unlock just before it is ignored, and the register keeps its value.
- R4: Any bus write re-locks the register. This covers a write to another address, a key write with a value other than 0xA7, and the write that consumed the unlock. A later write to 0xC5 is then ignored.
- R5: Power register bit 6 drives the meter shutdown output, and bit 4 drives the core shutdown request.
- R6: Reads of 0xC5 return bit 6, bit 4 and the divide code in bits [2:0]. Bits 7, 5 and 3 always read 0, and bit 5 is never stored.
- R7: The core clock enable is a one-cycle pulse every 2^code cycles. Code 0 holds it high on every cycle, and code 7 gives a period of 128 cycles.
- R8: Every accepted power register write restarts the divider, so the first pulse appears 2^code − 1 cycles after the cycle that follows the write edge.
- R9: Addresses 0xFB to 0xFE hold four independent 8-bit scratch registers that can be read and written.
- R10: The scratch registers keep their values through a system reset and are cleared to 0 by the power-loss reset.
- R11: The power-loss reset also returns the power register and the lock to their defaults.
- R12: Reads of any address other than 0xC5 and 0xFB to 0xFE return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| sysRstN | input | 1 | Active-low system reset; scratch registers kept |
| porRstN | input | 1 | Active-low power-loss reset; clears everything |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busRdata | output | 8 | Read data, combinational |
| meterOff | output | 1 | Metering shutdown flag |
| coreOff | output | 1 | Core shutdown request |
| coreClkEn | output | 1 | Divided core clock enable pulse |

## Verification
The bench puts a foreign write, a wrong key value and a second power write after the unlock. A design that kept the unlock open too long would then change the register. It also puts a read between the key and the power write, so a design that re-locked on reads would drop a legal write. Divider periods are measured at codes 0, 2, 3 and 7, together with the delay to the first pulse after a write. An off-by-one limit or a counter that is not restarted would show a wrong gap. The two resets are applied one after the other, which catches scratch registers tied to the wrong reset.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
  localparam int DATA_W  = 8;
  localparam int CD_W    = 3;
  localparam int NUM_SCR = 4;
  localparam int SEL_W   = $clog2(NUM_SCR);

  localparam logic [DATA_W-1:0] KEY_ADDR  = 8'hC1;
  localparam logic [DATA_W-1:0] PWR_ADDR  = 8'hC5;
  localparam logic [DATA_W-1:0] SCR_BASE  = 8'hFB;
  localparam logic [DATA_W-1:0] KEY_VALUE = 8'hA7;
  localparam logic [CD_W-1:0]   CD_RESET  = 3'd2;

  localparam int METER_BIT = 6;
  localparam int CORE_BIT  = 4;

  typedef enum logic [1:0] {RD_NONE, RD_PWR, RD_SCR} rdSel_e;

  typedef struct packed {
    logic             pwrWr;
    logic             scrWr;
    logic [SEL_W-1:0] scrSel;
    rdSel_e           rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/pwrctl_ctrl.sv
module pwrctl_ctrl
  import pwrctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output ctlStrobes_t       strb
);
  logic       unlocked;
  logic       keyWr;
  logic [8:0] scrOff;
  logic       scrHit;

  assign keyWr  = busWr && (busAddr == KEY_ADDR) && (busWdata == KEY_VALUE);
  assign scrOff = {1'b0, busAddr} - {1'b0, SCR_BASE};
  assign scrHit = (scrOff < 9'(NUM_SCR));

  // the lock opens for exactly one following write
  always_ff @(posedge clk) begin
    if (!rstN)      unlocked <= 1'b0;
    else if (busWr) unlocked <= keyWr;
  end

  always_comb begin
    strb.pwrWr  = busWr && (busAddr == PWR_ADDR) && unlocked;
    strb.scrWr  = busWr && scrHit;
    strb.scrSel = scrOff[SEL_W-1:0];
    if (!busRd)                    strb.rdSel = RD_NONE;
    else if (busAddr == PWR_ADDR)  strb.rdSel = RD_PWR;
    else if (scrHit)               strb.rdSel = RD_SCR;
    else                           strb.rdSel = RD_NONE;
  end

  assert_relock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !(busAddr == KEY_ADDR && busWdata == KEY_VALUE)) |=> !strb.pwrWr);

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == KEY_ADDR && busWdata == KEY_VALUE)
      |=> ((busWr && busAddr == PWR_ADDR) == strb.pwrWr));

  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pwrWr && strb.scrWr));
endmodule

// File: rtl/pwrctl_clkdiv.sv
module pwrctl_clkdiv #(
  parameter int CD_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            restart,
  input  logic [CD_W-1:0] cd,
  output logic            tick
);
  localparam int CNT_W = (1 << CD_W) - 1;
  localparam logic [CD_W:0] CNT_WL = CNT_W[CD_W:0];

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = {CNT_W{1'b1}} >> (CNT_WL - {1'b0, cd});
  assign tick  = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN)                 cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limit);

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cd != '0 && !restart) |=> !tick);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (cnt == '0));
endmodule

// File: rtl/pwrctl_dp.sv
module pwrctl_dp
  import pwrctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              porRstN,
  input  logic [DATA_W-1:0] busWdata,
  input  ctlStrobes_t       strb,
  output logic [DATA_W-1:0] busRdata,
  output logic              meterOff,
  output logic              coreOff,
  output logic              coreClkEn
);
  logic [CD_W-1:0]                  cdField;
  logic                             meterQ;
  logic                             coreQ;
  logic [NUM_SCR-1:0][DATA_W-1:0]   scr;
  logic [DATA_W-1:0]                pwrRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cdField <= CD_RESET;
      meterQ  <= 1'b0;
      coreQ   <= 1'b0;
    end else if (strb.pwrWr) begin
      cdField <= busWdata[CD_W-1:0];
      meterQ  <= busWdata[METER_BIT];
      coreQ   <= busWdata[CORE_BIT];
    end
  end

  // scratch storage answers only to the power-loss reset
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      scr <= '0;
    end else begin
      for (int i = 0; i < NUM_SCR; i++) begin
        if (strb.scrWr && strb.scrSel == SEL_W'(i)) scr[i] <= busWdata;
      end
    end
  end

  always_comb begin
    pwrRead            = '0;
    pwrRead[CD_W-1:0]  = cdField;
    pwrRead[CORE_BIT]  = coreQ;
    pwrRead[METER_BIT] = meterQ;
    case (strb.rdSel)
      RD_PWR:  busRdata = pwrRead;
      RD_SCR:  busRdata = scr[strb.scrSel];
      default: busRdata = '0;
    endcase
  end

  assign meterOff = meterQ;
  assign coreOff  = coreQ;

  pwrctl_clkdiv #(.CD_W(CD_W)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strb.pwrWr),
    .cd      (cdField),
    .tick    (coreClkEn)
  );

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pwrWr |=> $stable({meterQ, coreQ, cdField}));

  assert_scr_keep_R10: assert property (@(posedge clk) disable iff (!porRstN)
    !strb.scrWr |=> $stable(scr));

  assert_reset_value_R1: assert property (@(posedge clk)
    !rstN |=> (cdField == CD_RESET && !meterOff && !coreOff));
endmodule

// File: rtl/pwr_key_ctl.sv
module pwr_key_ctl
  import pwrctl_pkg::*;
(
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              porRstN,
  input  logic [DATA_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  output logic              meterOff,
  output logic              coreOff,
  output logic              coreClkEn
);
  logic        rstN;
  ctlStrobes_t strb;

  // power loss implies a full system reset (R11)
  assign rstN = sysRstN & porRstN;

  pwrctl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWr    (busWr),
    .busRd    (busRd),
    .strb     (strb)
  );

  pwrctl_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .porRstN   (porRstN),
    .busWdata  (busWdata),
    .strb      (strb),
    .busRdata  (busRdata),
    .meterOff  (meterOff),
    .coreOff   (coreOff),
    .coreClkEn (coreClkEn)
  );
endmodule

// File: tb/sim_pwr_key_ctl.sv
module sim_pwr_key_ctl;
  logic       clk = 1'b0;
  logic       sysRstN = 1'b0;
  logic       porRstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdata;
  logic       meterOff, coreOff, coreClkEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } rdItem_t;
  rdItem_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  pwr_key_ctl u0 (
    .clk(clk), .sysRstN(sysRstN), .porRstN(porRstN),
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .busRdata(busRdata), .meterOff(meterOff), .coreOff(coreOff),
    .coreClkEn(coreClkEn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data while a read is on the bus
  always @(negedge clk) begin
    #5;
    if (busRd) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "scoreboard underflow", busRdata, 0);
      end else begin
        rdItem_t it;
        it = expQ.pop_front();
        chk(busRdata === it.exp, it.tag, busRdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    rdItem_t it;
    it.exp = e; it.tag = tag;
    @(negedge clk);
    expQ.push_back(it);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitTick(output int n);
    n = 0;
    while (!coreClkEn && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  // called right after an accepted write to 0xC5 with code cd
  task automatic measureDiv(input int cd, input string tag);
    int first, gap;
    waitTick(first);
    chk(first == (1 << cd) - 1, {tag, " R8 first pulse delay"}, first, (1 << cd) - 1);
    @(negedge clk);
    waitTick(gap);
    gap = gap + 1;
    chk(gap == (1 << cd), {tag, " R7 pulse period"}, gap, 1 << cd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    sysRstN = 1'b1; porRstN = 1'b1;

    // R1 defaults
    rd(8'hC5, 8'h02, "R1 power reg default");
    rd(8'hC1, 8'h00, "R1 key reads zero");
    chk(meterOff == 1'b0, "R1 meterOff default", meterOff, 0);
    chk(coreOff == 1'b0, "R1 coreOff default", coreOff, 0);
    // R7 default period 4
    @(negedge clk); waitTick(g); @(negedge clk); waitTick(g);
    chk(g + 1 == 4, "R7 default period", g + 1, 4);

    // R12 unmapped reads
    rd(8'h80, 8'h00, "R12 unmapped 0x80");
    rd(8'hFA, 8'h00, "R12 unmapped 0xFA");
    rd(8'hFF, 8'h00, "R12 unmapped 0xFF");

    // R3 write without key
    wr(8'hC5, 8'h55);
    rd(8'hC5, 8'h02, "R3 unkeyed write ignored");

    // R2 / R6 / R5 keyed write of all ones
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'hFF);
    rd(8'hC5, 8'h57, "R6 reserved bits read zero");
    chk(meterOff == 1'b1, "R5 meterOff set", meterOff, 1);
    chk(coreOff == 1'b1, "R5 coreOff set", coreOff, 1);

    // R4 foreign write between key and target
    wr(8'hC1, 8'hA7); wr(8'hFB, 8'h11); wr(8'hC5, 8'h00);
    rd(8'hC5, 8'h57, "R4 foreign write relocks");
    rd(8'hC1, 8'h00, "R1 key reads zero after unlock");

    // R4 second write after unlock
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'h10); wr(8'hC5, 8'h00);
    rd(8'hC5, 8'h10, "R4 second write ignored");
    chk(coreOff == 1'b1, "R5 core shutdown request", coreOff, 1);
    chk(meterOff == 1'b0, "R5 meterOff cleared", meterOff, 0);

    // R4 wrong key value
    wr(8'hC1, 8'hA6); wr(8'hC5, 8'h03);
    rd(8'hC5, 8'h10, "R4 wrong key ignored");

    // R2 read between key and write keeps unlock
    wr(8'hC1, 8'hA7);
    rd(8'hFB, 8'h11, "R9 scratch readback");
    wr(8'hC5, 8'h40);
    rd(8'hC5, 8'h40, "R2 read does not relock");
    chk(meterOff == 1'b1 && coreOff == 1'b0, "R5 meter only", {meterOff, coreOff}, 2'b10);

    // R7 / R8 divider codes
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'h00); measureDiv(0, "cd0");
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'h02); measureDiv(2, "cd2");
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'h03); measureDiv(3, "cd3");
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'h07); measureDiv(7, "cd7");

    // R9 scratch registers
    wr(8'hFB, 8'h3C); wr(8'hFC, 8'hC3); wr(8'hFD, 8'h5A); wr(8'hFE, 8'hA5);
    rd(8'hFB, 8'h3C, "R9 scratch 0");
    rd(8'hFC, 8'hC3, "R9 scratch 1");
    rd(8'hFD, 8'h5A, "R9 scratch 2");
    rd(8'hFE, 8'hA5, "R9 scratch 3");

    // R10 system reset keeps scratch
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'h55);
    @(negedge clk); sysRstN = 1'b0;
    repeat (2) @(negedge clk); sysRstN = 1'b1;
    rd(8'hFD, 8'h5A, "R10 scratch kept on system reset");
    rd(8'hC5, 8'h02, "R1 power reg after system reset");

    // R11 power-loss reset clears all
    wr(8'hC1, 8'hA7); wr(8'hC5, 8'h50);
    wr(8'hC1, 8'hA7);
    @(negedge clk); porRstN = 1'b0;
    repeat (2) @(negedge clk); porRstN = 1'b1;
    rd(8'hFB, 8'h00, "R10 scratch cleared by power loss");
    rd(8'hFE, 8'h00, "R10 scratch 3 cleared");
    rd(8'hC5, 8'h02, "R11 power reg after power loss");
    chk(meterOff == 1'b0 && coreOff == 1'b0, "R11 outputs cleared", {meterOff, coreOff}, 0);
    wr(8'hC5, 8'h13);
    rd(8'hC5, 8'h02, "R11 lock cleared by power loss");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule